// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

The aggregator collects 256 interrupt lines from peripheral circuits, grouped as 32 blocks of 8 lines, and folds them into one active-high request to a host. Pending state is summarised in three levels: a byte of pending lines per block, a master byte per group of 8 blocks, and a root byte with one bit per master. The host walks that tree through a small byte-wide register window. It reads the root, then the master bytes, then the pending byte of each block it has selected.

Each line has its own trigger setup: edge or level mode, plus separate enables for the two polarities. The register window is indirect. The host first writes a block number into a selection register. It then writes a configuration byte that carries a line index within that block, the mode bits, a clear flag and a write-enable flag. The same selection register also picks which block's pending byte and which block's synchronised raw input levels the host reads.

Top module: `hier_irq_agg`

## Requirements
- R1: After reset, every line is in edge mode with both polarity masks set and is not pending. `irq_out` is low, every status byte reads 0, and the configuration readback of line 0 reads 0x06.
- R2: The window sits at offsets from `BASE_ADDR`: root +0, masters 0..3 at +1..+4, block select +5, pending byte of the selected block +6, configuration readback +7, raw level byte of the selected block +8. Reads return data in the cycle after the read strobe. Offsets outside the window read 0.
- R3: Root bit 0 always reads 0. Master m is summarised at root bit m+1. `irq_out` is high exactly when some root bit is set.
- R4: Bit i of master byte m is set when block m*8+i has any pending line. Bit i of a block's pending byte is line block*8+i.
- R5: The configuration byte has these fields: bit 7 write enable, bits 6:4 line index, bit 3 clear, bit 2 rising/high mask, bit 1 falling/low mask, bit 0 level mode. A write with bit 7 at 0 changes no configuration, no pending bit and no readback pointer.
- R6: In edge mode with the rising mask clear, a 0-to-1 transition of the synchronised input sets the line pending. The pending bit then stays set after the input falls.
- R7: In edge mode with the falling mask clear, a 1-to-0 transition sets pending. Clearing both masks detects both edges.
- R8: In level mode, a clear rising mask means active-high and a clear falling mask means active-low. Pending is set while the input is at its active level, and it sets again in the cycle after a clear if the input is still active.
- R9: A line with both masks set never becomes pending.
- R10: An accepted write with the clear bit set drops that line's pending bit on the next edge. New events for that line are not taken in the write cycle itself.
- R11: The raw status byte shows the inputs of the selected block after a two-flop synchroniser. A change on an input appears in the third read issued after it.
- R12: Configuration readback returns {0, index, 0, rising mask, falling mask, level} for the line given by the block select and the index of the last accepted configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_in | input | NUM_BLOCKS*8 | Asynchronous interrupt lines |
| irq_out | output | 1 | Active-high request to the host |

## Verification
The following are checked on every cycle:
- Root bit 0 stays at 0, and `irq_out` agrees with the root byte.
- A write without the enable bit leaves all configuration state unchanged.
- A line with both masks set stays idle.
- A level-high line at its active level becomes pending.
- A clear-flagged write empties the addressed line's pending bit.

Some behaviours depend on a chosen input history and on specific addresses, so only the directed scenarios can show them:
- The mapping of lines to block, master and root bits.
- Edge detection of either polarity, and the latching of an edge after the input returns.
- Re-arming of a level line after a clear.
- The two-read delay of the raw status path.
- Configuration readback.

// File: rtl/hia_pkg.sv
package hia_pkg;

  localparam int LINES_PER_BLK = 8;

  localparam logic [3:0] OFS_ROOT = 4'd0;
  localparam logic [3:0] OFS_BSEL = 4'd5;
  localparam logic [3:0] OFS_PEND = 4'd6;
  localparam logic [3:0] OFS_CFG  = 4'd7;
  localparam logic [3:0] OFS_RAW  = 4'd8;
  localparam logic [3:0] OFS_LAST = 4'd8;

  typedef struct packed {
    logic       we;
    logic [2:0] idx;
    logic       clr;
    logic       mask_rise;
    logic       mask_fall;
    logic       lvl_mode;
  } cfg_byte_t;

  // Set condition of one line from its configuration and input history.
  function automatic logic line_fire(input logic lvl_mode, input logic mask_fall,
                                     input logic mask_rise, input logic cur,
                                     input logic prev);
    if (lvl_mode)
      return (!mask_rise && cur) || (!mask_fall && !cur);
    else
      return (!mask_rise && cur && !prev) || (!mask_fall && !cur && prev);
  endfunction

  // Byte returned by a configuration readback.
  function automatic logic [7:0] cfg_readback(input logic [2:0] idx, input logic lvl_mode,
                                              input logic mask_fall, input logic mask_rise);
    return {1'b0, idx, 1'b0, mask_rise, mask_fall, lvl_mode};
  endfunction

endpackage

// File: rtl/hia_sync.sv
module hia_sync #(
  parameter int W      = 256,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hia_line_bank.sv
module hia_line_bank #(
  parameter int NUM_LINES = 256,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl_in,
  input  logic                 cfg_we,
  input  logic [LINE_W-1:0]    cfg_line,
  input  logic                 cfg_lvl,
  input  logic                 cfg_mfall,
  input  logic                 cfg_mrise,
  input  logic                 cfg_clr,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] lvl_q,
  output logic [NUM_LINES-1:0] mfall_q,
  output logic [NUM_LINES-1:0] mrise_q,
  output logic [NUM_LINES-1:0] hit
);
  import hia_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic prev_q;
    logic fire;

    assign hit[g] = cfg_we && (cfg_line == LINE_W'(g));
    assign fire   = line_fire(lvl_q[g], mfall_q[g], mrise_q[g], lvl_in[g], prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q     <= 1'b0;
        lvl_q[g]   <= 1'b0;
        mfall_q[g] <= 1'b1;
        mrise_q[g] <= 1'b1;
        pend[g]    <= 1'b0;
      end else begin
        prev_q <= lvl_in[g];
        if (hit[g]) begin
          lvl_q[g]   <= cfg_lvl;
          mfall_q[g] <= cfg_mfall;
          mrise_q[g] <= cfg_mrise;
          if (cfg_clr) pend[g] <= 1'b0;
        end else if (fire) begin
          pend[g] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hia_summary.sv
module hia_summary #(
  parameter int NUM_BLOCKS  = 32,
  parameter int NUM_MASTERS = (NUM_BLOCKS + 7) / 8,
  parameter int NUM_LINES   = NUM_BLOCKS * 8
) (
  input  logic [NUM_LINES-1:0]     pend,
  output logic [NUM_BLOCKS-1:0]    blk_any,
  output logic [NUM_MASTERS*8-1:0] master_flat,
  output logic [7:0]               root
);
  localparam int PAD = NUM_MASTERS * 8;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blk_any[b] = |pend[b*8 +: 8];
  end

  for (genvar p = 0; p < PAD; p++) begin : g_pad
    if (p < NUM_BLOCKS) begin : g_real
      assign master_flat[p] = blk_any[p];
    end else begin : g_zero
      assign master_flat[p] = 1'b0;
    end
  end

  always_comb begin
    root = '0;
    for (int m = 0; m < NUM_MASTERS; m++) root[m+1] = |master_flat[m*8 +: 8];
  end
endmodule

// File: rtl/hier_irq_agg.sv
module hier_irq_agg #(
  parameter int                NUM_BLOCKS  = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h1BB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [7:0]              reg_wdata,
  input  logic                    reg_rd,
  output logic [7:0]              reg_rdata,
  input  logic [NUM_BLOCKS*8-1:0] irq_in,
  output logic                    irq_out
);
  import hia_pkg::*;

  localparam int NUM_LINES   = NUM_BLOCKS * 8;
  localparam int NUM_MASTERS = (NUM_BLOCKS + 7) / 8;
  localparam int BLK_W       = $clog2(NUM_BLOCKS);
  localparam int LINE_W      = BLK_W + 3;

  // Address decode
  logic [ADDR_W-1:0] off;
  logic [3:0]        off_lo;
  logic              in_win;
  assign off    = reg_addr - BASE_ADDR;
  assign off_lo = off[3:0];
  assign in_win = (reg_addr >= BASE_ADDR) && (off <= ADDR_W'(OFS_LAST));

  // Named events for the checker
  cfg_byte_t cfg_b;
  logic      cfg_wr_seen, cfg_accept, cfg_clr, bsel_wr, rd_is_root;
  assign cfg_b       = cfg_byte_t'(reg_wdata);
  assign cfg_wr_seen = reg_wr && in_win && (off_lo == OFS_CFG);
  assign cfg_accept  = cfg_wr_seen && cfg_b.we;
  assign cfg_clr     = cfg_b.clr;
  assign bsel_wr     = reg_wr && in_win && (off_lo == OFS_BSEL);
  assign rd_is_root  = reg_rd && in_win && (off_lo == OFS_ROOT);

  // Selection state
  logic [BLK_W-1:0] blk_sel;
  logic [2:0]       rd_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_sel <= '0;
      rd_idx  <= '0;
    end else begin
      if (bsel_wr)    blk_sel <= reg_wdata[BLK_W-1:0];
      if (cfg_accept) rd_idx  <= cfg_b.idx;
    end
  end

  // Line datapath
  logic [NUM_LINES-1:0] sync_lvl, pend, lvl_q, mfall_q, mrise_q, hit;
  logic [LINE_W-1:0]    cfg_line, rd_line;
  assign cfg_line = {blk_sel, cfg_b.idx};
  assign rd_line  = {blk_sel, rd_idx};

  hia_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_in), .q_sync(sync_lvl)
  );

  hia_line_bank #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .lvl_in(sync_lvl),
    .cfg_we(cfg_accept), .cfg_line(cfg_line), .cfg_lvl(cfg_b.lvl_mode),
    .cfg_mfall(cfg_b.mask_fall), .cfg_mrise(cfg_b.mask_rise), .cfg_clr(cfg_b.clr),
    .pend(pend), .lvl_q(lvl_q), .mfall_q(mfall_q), .mrise_q(mrise_q), .hit(hit)
  );

  logic [NUM_BLOCKS-1:0]    blk_any;
  logic [NUM_MASTERS*8-1:0] master_flat;
  logic [7:0]               root;

  hia_summary #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_MASTERS(NUM_MASTERS), .NUM_LINES(NUM_LINES)) u_sum (
    .pend(pend), .blk_any(blk_any), .master_flat(master_flat), .root(root)
  );

  assign irq_out = |blk_any;

  // Read mux
  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (in_win) begin
      unique case (off_lo)
        OFS_ROOT: rd_byte = root;
        OFS_BSEL: rd_byte = 8'(blk_sel);
        OFS_PEND: rd_byte = pend[blk_sel*8 +: 8];
        OFS_CFG:  rd_byte = cfg_readback(rd_idx, lvl_q[rd_line], mfall_q[rd_line], mrise_q[rd_line]);
        OFS_RAW:  rd_byte = sync_lvl[blk_sel*8 +: 8];
        default: begin
          for (int m = 0; m < NUM_MASTERS; m++)
            if (off_lo == 4'(m + 1)) rd_byte = master_flat[m*8 +: 8];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_byte;
  end
endmodule

// File: rtl/hier_irq_agg_chk.sv
module hier_irq_agg_chk #(
  parameter int NUM_LINES = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_out,
  input logic [7:0]           root,
  input logic [7:0]           reg_rdata,
  input logic                 rd_is_root,
  input logic                 cfg_wr_seen,
  input logic                 cfg_accept,
  input logic                 cfg_clr,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] lvl_q,
  input logic [NUM_LINES-1:0] mfall_q,
  input logic [NUM_LINES-1:0] mrise_q,
  input logic [NUM_LINES-1:0] sync_lvl,
  input logic [NUM_LINES-1:0] hit
);
  // R3
  root_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n) !root[0]);

  // R3
  irq_root_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_out == (root != 8'h00));

  // R3
  rd_root_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_root |=> !reg_rdata[0]);

  // R5
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_seen && !cfg_accept) |=> ($stable(lvl_q) && $stable(mfall_q) && $stable(mrise_q)));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mfall_q[i] && mrise_q[i] && !pend[i]) |=> !pend[i]);

    // R8
    lvl_high_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[i] && !mrise_q[i] && sync_lvl[i] && !hit[i]) |=> pend[i]);

    // R10
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && cfg_clr) |=> !pend[i]);
  end
endmodule

bind hier_irq_agg hier_irq_agg_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .root(root), .reg_rdata(reg_rdata),
  .rd_is_root(rd_is_root), .cfg_wr_seen(cfg_wr_seen), .cfg_accept(cfg_accept),
  .cfg_clr(cfg_clr), .pend(pend), .lvl_q(lvl_q), .mfall_q(mfall_q), .mrise_q(mrise_q),
  .sync_lvl(sync_lvl), .hit(hit)
);

// File: tb/hier_irq_agg_tb.sv
`timescale 1ns/1ps
module hier_irq_agg_tb;
  localparam int         NB   = 32;
  localparam logic [9:0] BASE = 10'h1BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_rdata;
  logic [NB*8-1:0] irq_in = '0;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hier_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ofs, input logic [7:0] d);
    reg_addr = BASE + 10'(ofs); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [7:0] d);
    reg_addr = BASE + 10'(ofs); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int ofs, input logic [7:0] exp);
    logic [7:0] v;
    rd(ofs, v);
    chk(req, v, exp);
  endtask

  // Config byte: we, idx[2:0], clr, mask_rise, mask_fall, lvl
  task automatic cfg(input int line, input bit lvl, input bit mfall, input bit mrise, input bit clr);
    wr(5, 8'(line / 8));
    wr(7, {1'b1, 3'(line % 8), clr, mrise, mfall, lvl});
  endtask

  task automatic t_reset;
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd_chk("R1 root", 0, 8'h00);
    for (int m = 1; m <= 4; m++) rd_chk("R1 master", m, 8'h00);
    rd_chk("R1 bsel", 5, 8'h00);
    rd_chk("R1 pend", 6, 8'h00);
    rd_chk("R1 cfg readback", 7, 8'h06);
    rd_chk("R2 unmapped", 9, 8'h00);
  endtask

  task automatic t_rise;
    cfg(83, 0, 1, 0, 1);
    irq_in[83] = 1'b1; idle(5);
    chk("R3 irq_out set", {7'd0, irq_out}, 8'h01);
    rd_chk("R3 root bit2", 0, 8'h04);
    rd_chk("R4 master1", 2, 8'h04);
    rd_chk("R4 pend blk10", 6, 8'h08);
    rd_chk("R12 readback", 7, 8'h32);
    irq_in[83] = 1'b0; idle(5);
    rd_chk("R6 edge latched", 6, 8'h08);
    cfg(83, 0, 1, 0, 1); idle(2);
    rd_chk("R10 cleared", 6, 8'h00);
    chk("R3 irq_out low", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_fall;
    irq_in[200] = 1'b1; idle(5);
    cfg(200, 0, 0, 1, 1);
    rd_chk("R7 no edge yet", 6, 8'h00);
    irq_in[200] = 1'b0; idle(5);
    rd_chk("R7 fall pend", 6, 8'h01);
    rd_chk("R3 root bit4", 0, 8'h10);
    rd_chk("R4 master3", 4, 8'h02);
    cfg(201, 0, 0, 0, 1);
    irq_in[201] = 1'b1; idle(5);
    rd_chk("R7 both rise", 6, 8'h03);
    cfg(201, 0, 0, 0, 1);
    cfg(200, 0, 0, 1, 1); idle(2);
    rd_chk("R10 both clear", 6, 8'h00);
    irq_in[201] = 1'b0; idle(5);
    rd_chk("R7 both fall", 6, 8'h02);
    cfg(201, 0, 1, 1, 1); idle(2);
  endtask

  task automatic t_level;
    cfg(5, 1, 1, 0, 1);
    irq_in[5] = 1'b1; idle(5);
    rd_chk("R8 level high", 6, 8'h20);
    cfg(5, 1, 1, 0, 1); idle(2);
    rd_chk("R8 re-set after clear", 6, 8'h20);
    irq_in[5] = 1'b0; idle(5);
    rd_chk("R8 held", 6, 8'h20);
    cfg(5, 1, 1, 0, 1); idle(2);
    rd_chk("R10 level cleared", 6, 8'h00);
    cfg(6, 1, 0, 1, 1); idle(5);
    rd_chk("R8 level low", 6, 8'h40);
    irq_in[6] = 1'b1; idle(5);
    cfg(6, 1, 0, 1, 1); idle(2);
    rd_chk("R8 low cleared", 6, 8'h00);
  endtask

  task automatic t_disable;
    cfg(83, 0, 1, 1, 1);
    irq_in[83] = 1'b1; idle(5);
    irq_in[83] = 1'b0; idle(5);
    rd_chk("R9 edge disabled", 6, 8'h00);
    cfg(5, 1, 1, 1, 1);
    irq_in[5] = 1'b1; idle(5);
    rd_chk("R9 level disabled", 6, 8'h00);
    chk("R9 irq_out", {7'd0, irq_out}, 8'h00);
    irq_in[5] = 1'b0; idle(3);
  endtask

  task automatic t_ignore;
    cfg(40, 0, 1, 0, 1);
    irq_in[40] = 1'b1; idle(5);
    irq_in[40] = 1'b0; idle(3);
    rd_chk("R6 line40", 6, 8'h01);
    wr(7, 8'h08); idle(2);
    rd_chk("R5 ignored clear", 6, 8'h01);
    rd_chk("R5 readback kept", 7, 8'h02);
    wr(7, 8'h1A);
    irq_in[41] = 1'b1; idle(5);
    rd_chk("R5 ignored cfg", 6, 8'h01);
    rd_chk("R5 pointer kept", 7, 8'h02);
    cfg(40, 0, 1, 1, 1);
    irq_in[41] = 1'b0; idle(3);
    rd_chk("R10 line40 clear", 6, 8'h00);
  endtask

  task automatic t_raw;
    wr(5, 8'd17);
    irq_in[136 +: 8] = 8'hA5;
    rd_chk("R11 sync 1st", 8, 8'h00);
    rd_chk("R11 sync 2nd", 8, 8'h00);
    rd_chk("R11 sync 3rd", 8, 8'hA5);
    rd_chk("R2 bsel", 5, 8'd17);
    rd_chk("R9 raw lines masked", 6, 8'h00);
    irq_in[136 +: 8] = 8'h00; idle(3);
    rd_chk("R11 raw low", 8, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_rise;
    t_fall;
    t_level;
    t_disable;
    t_ignore;
    t_raw;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule